// File: doc/BRIEF.md
# Power-Up Configuration Table Loader

This block sets up a parameter register file once, right after power-up. It holds the register file at built-in defaults until the self-test reports completion. On that event it samples a three-bit table-select strap, which comes from an external resistor measurement, and a flag that tells whether a resistor was found on the configuration pin at all. If a resistor was found, the block copies the selected table from an internal ROM into the register file, one address/data pair per clock. A copy ends early at a reserved end-marker entry.

After the copy comes a restore step. Stored settings from non-volatile storage arrive as a stream of address/data beats. A precedence input decides whether a stored setting may replace a register that the table wrote. The phase then closes and a sticky done flag rises. The measurement-current enable drops. The strap, the pin flag and the self-test signal are ignored until the next reset. Only after that may the host bus write registers. A cycle budget forces completion if the stored-settings stream never ends.

Top module: `cfg_strap_loader`

## Requirements
- R1: After reset, `cfg_done` is 0 and `meas_en` is 1. Every register at address a reads 16'hA000 + a.
- R2: On the first clock where `bist_done` is high, the block latches `strap_sel` = t. With `strap_valid` = 1, table t is then copied. Entry i writes address 2t+i with data t*4096 + 37i + 5. Table t holds 4t+2 entries, except table 7, which holds all 32. An entry whose address is 63 is the end marker: it is never written and it stops the copy.
- R3: If `strap_valid` is 0 when the strap is latched, no table entry is written and the registers keep their defaults.
- R4: In the restore step, every accepted `nvm_vld` beat writes `nvm_data` to `nvm_addr`. A beat that also has `nvm_last` high ends the phase, and `cfg_done` is 1 after the next clock edge.
- R5: If `nvm_prio` is 0, a restore beat to a register that the table wrote is dropped. If `nvm_prio` is 1, every restore beat overwrites.
- R6: A restore beat given while the table is still being copied is dropped.
- R7: Once `cfg_done` is 1, it stays 1 and `meas_en` stays 0. Later changes on `strap_sel`, `strap_valid`, `bist_done` and the restore inputs change no register.
- R8: Let E0 be the clock edge that samples `bist_done`. `cfg_done` becomes 1 no later than the edge BUDGET edges after E0, even if `nvm_last` never arrives.
- R9: A host write (`host_we`) takes effect only while `cfg_done` is 1. A host write given before that is ignored.
- R10: Before `bist_done` is seen, no register is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset (power-up) |
| bist_done | input | 1 | Self-test finished; starts the configuration phase |
| strap_sel | input | 3 | Table index taken from the resistor measurement |
| strap_valid | input | 1 | A resistor was detected on the configuration pin |
| nvm_prio | input | 1 | 1: stored settings override table values |
| nvm_vld | input | 1 | Stored-setting beat valid |
| nvm_addr | input | 6 | Stored-setting register address |
| nvm_data | input | 16 | Stored-setting value |
| nvm_last | input | 1 | Final stored-setting beat |
| host_we | input | 1 | Host register write strobe |
| host_addr | input | 6 | Host write address |
| host_wdata | input | 16 | Host write data |
| rd_addr | input | 6 | Register read address |
| rd_data | output | 16 | Register read data (combinational) |
| cfg_done | output | 1 | Configuration phase complete (sticky) |
| meas_en | output | 1 | Measurement current enable |

## Verification
The copy is tried on all eight strap codes. The short tables show that the end marker stops the copy at the right length. The full last table shows that the copy also stops on the entry count alone. Runs with the pin flag low show the default path and prove that the strap then has no effect. Each table's footprint is compared with a fixed stored-settings stream that overlaps some tables and not others, under both precedence values, which separates the drop and overwrite cases. Early host writes and early restore beats, stimulus after completion, and a stream with no final beat test the gating and the cycle budget.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;
  typedef enum logic [1:0] {ST_WAIT, ST_COPY, ST_RESTORE, ST_DONE} seq_state_e;

  // entry count for table t; the last table fills the full depth
  function automatic int tbl_len(input int t, input int tables, input int pairs);
    int n;
    n = 4 * t + 2;
    if (t == tables - 1 || n > pairs) n = pairs;
    return n;
  endfunction

  function automatic int ent_addr(input int t, input int i);
    return i + 2 * t;
  endfunction

  function automatic int ent_data(input int t, input int i);
    return t * 4096 + i * 37 + 5;
  endfunction

  function automatic int dflt_val(input int a);
    return 32'hA000 + a;
  endfunction
endpackage

// File: rtl/cfg_table_rom.sv
module cfg_table_rom
  import cfg_loader_pkg::*;
#(
  parameter int TABLES = 8,
  parameter int PAIRS  = 32,
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16,
  localparam int SEL_W = $clog2(TABLES),
  localparam int IDX_W = $clog2(PAIRS)
) (
  input  logic [SEL_W-1:0]  sel,
  input  logic [IDX_W-1:0]  idx,
  output logic [ADDR_W-1:0] ent_addr_o,
  output logic [DATA_W-1:0] ent_data_o
);
  int rom_len;

  always_comb begin
    rom_len = tbl_len(int'(sel), TABLES, PAIRS);
    if (int'(idx) < rom_len) begin
      ent_addr_o = ADDR_W'(ent_addr(int'(sel), int'(idx)));
      ent_data_o = DATA_W'(ent_data(int'(sel), int'(idx)));
    end else begin
      ent_addr_o = '1;
      ent_data_o = '0;
    end
  end
endmodule

// File: rtl/cfg_seq_fsm.sv
module cfg_seq_fsm
  import cfg_loader_pkg::*;
#(
  parameter int TABLES = 8,
  parameter int PAIRS  = 32,
  parameter int ADDR_W = 6,
  parameter int BUDGET = 1000000,
  localparam int SEL_W = $clog2(TABLES),
  localparam int IDX_W = $clog2(PAIRS),
  localparam int TMR_W = $clog2(BUDGET + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bist_done,
  input  logic [SEL_W-1:0]  strap_sel,
  input  logic              strap_valid,
  input  logic              nvm_vld,
  input  logic              nvm_last,
  input  logic [ADDR_W-1:0] rom_addr,
  output seq_state_e        state_o,
  output logic [SEL_W-1:0]  sel_q,
  output logic              pin_q,
  output logic [IDX_W-1:0]  idx_q,
  output logic              copy_we
);
  seq_state_e       st;
  logic [TMR_W-1:0] tmr;
  logic             rom_is_end;
  logic             budget_hit;
  logic             last_idx;

  assign rom_is_end = (rom_addr == '1);
  assign budget_hit = (tmr == TMR_W'(BUDGET - 1));
  assign last_idx   = (idx_q == IDX_W'(PAIRS - 1));
  assign copy_we    = (st == ST_COPY) && !rom_is_end;
  assign state_o    = st;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= ST_WAIT;
      sel_q <= '0;
      pin_q <= 1'b0;
      idx_q <= '0;
      tmr   <= '0;
    end else begin
      case (st)
        ST_WAIT: begin
          if (bist_done) begin
            sel_q <= strap_sel;
            pin_q <= strap_valid;
            idx_q <= '0;
            tmr   <= '0;
            st    <= strap_valid ? ST_COPY : ST_RESTORE;
          end
        end
        ST_COPY: begin
          tmr <= tmr + TMR_W'(1);
          if (budget_hit) st <= ST_DONE;
          else if (rom_is_end || last_idx) st <= ST_RESTORE;
          else idx_q <= idx_q + IDX_W'(1);
        end
        ST_RESTORE: begin
          tmr <= tmr + TMR_W'(1);
          if (budget_hit || (nvm_vld && nvm_last)) st <= ST_DONE;
        end
        default: st <= ST_DONE;
      endcase
    end
  end
endmodule

// File: rtl/cfg_param_regfile.sv
module cfg_param_regfile
  import cfg_loader_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16,
  localparam int NREG  = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              mark,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic [ADDR_W-1:0] probe_addr,
  output logic              probe_tch
);
  logic [DATA_W-1:0] mem_w [NREG];
  logic [NREG-1:0]   tch_w;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic [DATA_W-1:0] q;
    logic              t;
    logic              hit;
    assign hit = we && (waddr == ADDR_W'(g));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        q <= DATA_W'(dflt_val(g));
        t <= 1'b0;
      end else if (hit) begin
        q <= wdata;
        t <= t | mark;
      end
    end
    assign mem_w[g] = q;
    assign tch_w[g] = t;
  end

  assign rd_data   = mem_w[rd_addr];
  assign probe_tch = tch_w[probe_addr];
endmodule

// File: rtl/cfg_strap_loader.sv
module cfg_strap_loader
  import cfg_loader_pkg::*;
#(
  parameter int TABLES = 8,
  parameter int PAIRS  = 32,
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16,
  parameter int BUDGET = 1000000,
  localparam int SEL_W = $clog2(TABLES),
  localparam int IDX_W = $clog2(PAIRS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bist_done,
  input  logic [SEL_W-1:0]  strap_sel,
  input  logic              strap_valid,
  input  logic              nvm_prio,
  input  logic              nvm_vld,
  input  logic [ADDR_W-1:0] nvm_addr,
  input  logic [DATA_W-1:0] nvm_data,
  input  logic              nvm_last,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              cfg_done,
  output logic              meas_en
);
  seq_state_e        st;
  logic [SEL_W-1:0]  sel_q;
  logic              pin_q;
  logic [IDX_W-1:0]  idx_q;
  logic [ADDR_W-1:0] copy_addr;
  logic [DATA_W-1:0] copy_data;
  logic              copy_we;
  logic              nvm_tch;

  // named events for the checker
  logic evt_copy_wr, evt_nvm_wr, evt_host_wr, cfg_active;

  logic              rf_we;
  logic [ADDR_W-1:0] rf_addr;
  logic [DATA_W-1:0] rf_data;

  cfg_table_rom #(.TABLES(TABLES), .PAIRS(PAIRS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) rom_i (
    .sel(sel_q), .idx(idx_q), .ent_addr_o(copy_addr), .ent_data_o(copy_data));

  cfg_seq_fsm #(.TABLES(TABLES), .PAIRS(PAIRS), .ADDR_W(ADDR_W), .BUDGET(BUDGET)) seq_i (
    .clk(clk), .rst_n(rst_n), .bist_done(bist_done), .strap_sel(strap_sel),
    .strap_valid(strap_valid), .nvm_vld(nvm_vld), .nvm_last(nvm_last),
    .rom_addr(copy_addr), .state_o(st), .sel_q(sel_q), .pin_q(pin_q),
    .idx_q(idx_q), .copy_we(copy_we));

  assign cfg_done    = (st == ST_DONE);
  assign meas_en     = !cfg_done;
  assign cfg_active  = (st == ST_COPY) || (st == ST_RESTORE);
  assign evt_copy_wr = copy_we;
  assign evt_nvm_wr  = (st == ST_RESTORE) && nvm_vld && (nvm_prio || !nvm_tch);
  assign evt_host_wr = cfg_done && host_we;

  always_comb begin
    rf_we   = evt_copy_wr || evt_nvm_wr || evt_host_wr;
    rf_addr = host_addr;
    rf_data = host_wdata;
    if (evt_copy_wr) begin
      rf_addr = copy_addr;
      rf_data = copy_data;
    end else if (evt_nvm_wr) begin
      rf_addr = nvm_addr;
      rf_data = nvm_data;
    end
  end

  cfg_param_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) rf_i (
    .clk(clk), .rst_n(rst_n), .we(rf_we), .waddr(rf_addr), .wdata(rf_data),
    .mark(evt_copy_wr), .rd_addr(rd_addr), .rd_data(rd_data),
    .probe_addr(nvm_addr), .probe_tch(nvm_tch));
endmodule

// File: rtl/cfg_strap_loader_chk.sv
module cfg_strap_loader_chk #(
  parameter int ADDR_W = 6,
  parameter int SEL_W  = 3,
  parameter int BUDGET = 1000000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_done,
  input logic              meas_en,
  input logic              cfg_active,
  input logic              pin_q,
  input logic [SEL_W-1:0]  sel_q,
  input logic [ADDR_W-1:0] copy_addr,
  input logic              evt_copy_wr,
  input logic              evt_nvm_wr,
  input logic              evt_host_wr
);
  int act_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n) act_cnt <= 0;
    else if (cfg_active) act_cnt <= act_cnt + 1;
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_active && !cfg_done) |-> !(evt_copy_wr || evt_nvm_wr || evt_host_wr)); // R10
  AST_END_NOT_WRITTEN: assert property (@(posedge clk) disable iff (!rst_n)
    evt_copy_wr |-> (copy_addr != '1)); // R2
  AST_FLOAT_NO_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_active && !pin_q) |-> !evt_copy_wr); // R3
  AST_ONE_WRITER: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({evt_copy_wr, evt_nvm_wr, evt_host_wr})); // R6
  AST_DONE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_done |=> cfg_done); // R7
  AST_MEAS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_done |-> !meas_en); // R7
  AST_SEL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_done && $past(cfg_done)) |-> $stable(sel_q)); // R7
  AST_HOST_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    evt_host_wr |-> cfg_done); // R9
  AST_BUDGET_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_active |-> (act_cnt < BUDGET)); // R8
endmodule

bind cfg_strap_loader cfg_strap_loader_chk #(.ADDR_W(ADDR_W), .SEL_W(SEL_W), .BUDGET(BUDGET)) chk_i (
  .clk(clk), .rst_n(rst_n), .cfg_done(cfg_done), .meas_en(meas_en),
  .cfg_active(cfg_active), .pin_q(pin_q), .sel_q(sel_q), .copy_addr(copy_addr),
  .evt_copy_wr(evt_copy_wr), .evt_nvm_wr(evt_nvm_wr), .evt_host_wr(evt_host_wr));

// File: tb/cfg_strap_loader_tb_top.sv
module cfg_strap_loader_tb_top;
  localparam int BUD = 300;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, bist_done, strap_valid, nvm_prio, nvm_vld, nvm_last, host_we;
  logic [2:0]  strap_sel;
  logic [5:0]  nvm_addr, host_addr, rd_addr;
  logic [15:0] nvm_data, host_wdata, rd_data;
  logic        cfg_done, meas_en;

  cfg_strap_loader #(.BUDGET(BUD)) dut_i (
    .clk(clk), .rst_n(rst_n), .bist_done(bist_done), .strap_sel(strap_sel),
    .strap_valid(strap_valid), .nvm_prio(nvm_prio), .nvm_vld(nvm_vld),
    .nvm_addr(nvm_addr), .nvm_data(nvm_data), .nvm_last(nvm_last),
    .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
    .rd_addr(rd_addr), .rd_data(rd_data), .cfg_done(cfg_done), .meas_en(meas_en));

  int n_cmp = 0;
  int n_bad = 0;
  logic [15:0] model [64];
  bit          owned [64];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic quiet();
    bist_done = 0; nvm_vld = 0; nvm_last = 0; nvm_addr = 0; nvm_data = 0;
    host_we = 0; host_addr = 0; host_wdata = 0; rd_addr = 0;
  endtask

  task automatic model_reset();
    for (int a = 0; a < 64; a++) begin
      model[a] = 16'(a | 'hA000);
      owned[a] = 0;
    end
  endtask

  // table t: the count grows by four per index, the last table is full
  task automatic model_table(input int t);
    int n;
    n = (t == 7) ? 32 : (t << 2) + 2;
    for (int i = 0; i < n; i++) begin
      model[t + t + i] = 16'((t << 12) + (i << 5) + (i << 2) + i + 5);
      owned[t + t + i] = 1;
    end
  endtask

  task automatic compare_all(input string tag);
    for (int a = 0; a < 64; a++) begin
      rd_addr = 6'(a);
      #1;
      chk($sformatf("%s reg%0d", tag, a), 32'(rd_data), 32'(model[a]));
    end
  endtask

  task automatic do_reset();
    quiet();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic run(input int t, input bit pin, input bit prio);
    string tg;
    tg = pin ? (prio ? "R2 R4 R5 prio1" : "R2 R4 R5 prio0") : "R3 R4 floating";
    do_reset();
    model_reset();
    chk("R1 done after reset", 32'(cfg_done), 0);
    chk("R1 meas_en after reset", 32'(meas_en), 1);
    strap_sel = 3'(t); strap_valid = pin; nvm_prio = prio;
    repeat (2) @(negedge clk);
    rd_addr = 6'(2 * t);
    #1 chk("R10 no copy before bist", 32'(rd_data), 32'(16'hA000 + 2 * t));
    bist_done = 1;
    @(negedge clk);
    host_we = 1; host_addr = 61; host_wdata = 16'h1111;
    if (pin) begin
      nvm_vld = 1; nvm_addr = 60; nvm_data = 16'h7777;
    end
    @(negedge clk);
    quiet(); bist_done = 1;
    repeat (45) @(negedge clk);
    chk("R4 not done before last beat", 32'(cfg_done), 0);
    if (pin) model_table(t);
    for (int k = 0; k < 5; k++) begin
      nvm_vld = 1; nvm_addr = 6'(3 * k); nvm_data = 16'(16'h5000 + k); nvm_last = (k == 4);
      if (prio || !owned[3 * k]) model[3 * k] = 16'(16'h5000 + k);
      @(negedge clk);
    end
    nvm_vld = 0; nvm_last = 0;
    chk("R4 done after last beat", 32'(cfg_done), 1);
    chk("R7 meas_en off", 32'(meas_en), 0);
    compare_all($sformatf("%s tbl%0d R6 R9", tg, t));
    strap_sel = 3'(t ^ 5); strap_valid = !pin; bist_done = 0;
    @(negedge clk);
    bist_done = 1; nvm_vld = 1; nvm_addr = 7; nvm_data = 16'hFFFF; nvm_last = 1;
    repeat (3) @(negedge clk);
    quiet();
    rd_addr = 7;
    #1 chk("R7 post-done inputs ignored", 32'(rd_data), 32'(model[7]));
    chk("R7 done held", 32'(cfg_done), 1);
    host_we = 1; host_addr = 61; host_wdata = 16'(16'h2000 + t);
    @(negedge clk);
    host_we = 0; rd_addr = 61;
    #1 chk("R9 host write after done", 32'(rd_data), 32'(16'h2000 + t));
  endtask

  task automatic budget_run();
    int k;
    do_reset();
    strap_sel = 2; strap_valid = 1; nvm_prio = 0;
    @(negedge clk);
    bist_done = 1;
    k = 0;
    while (!cfg_done && k < 3 * BUD) begin
      @(negedge clk);
      k++;
      if (k == 50) begin nvm_vld = 1; nvm_addr = 50; nvm_data = 16'h4242; end
      if (k == 51) nvm_vld = 0;
    end
    chk("R8 forced done cycle", 32'(k), 32'(BUD + 1));
    rd_addr = 50;
    #1 chk("R8 beat without last accepted", 32'(rd_data), 32'h4242);
  endtask

  initial begin
    #(200000 * 10);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    strap_sel = 0; strap_valid = 0; nvm_prio = 0;
    for (int t = 0; t < 8; t++) run(t, 1'b1, 1'b0);
    run(0, 1'b1, 1'b1);
    run(3, 1'b1, 1'b1);
    run(5, 1'b0, 1'b0);
    run(6, 1'b0, 1'b1);
    budget_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule